// File: doc/BRIEF.md
# Multi-Mode DMA Channel Sequencer

This block sequences one DMA channel in dual address mode. When enabled, it waits for a trigger from one of three sources: software auto-request, a peripheral interrupt line, or an external active-low request pin. For each data unit it then runs a read cycle at the source address and a write cycle at the destination address on a simple request/acknowledge bus master port. It counts down a 32-bit byte total unless free-running is selected. A 17-bit repeat/block counter drives the repeat and block modes.

The configuration inputs are sampled while the channel is disabled, which loads the working addresses and counters, and must stay stable while it is enabled. The repeat start addresses are taken live from the configuration address inputs. An external unit handles any address wrapping. This sequencer only moves addresses linearly and reloads them.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset `bus_req` and `done` are low.
- R2: Each unit is a read at the source address followed by a write of the read data to the destination address. `cfg_unit` selects the unit size: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes. Both addresses advance by that size after every unit.
- R3: `cfg_total` is a byte count. When it is used up, `done` rises and no further cycle is issued. A total of 0 raises `done` without any transfer.
- R4: With `cfg_free` set, the total is ignored and `done` never rises.
- R5: In normal mode (`cfg_mode` = 0), each accepted trigger moves exactly one unit, then the channel returns to idle.
- R6: In repeat mode (`cfg_mode` = 1), after `cfg_size` units both addresses reload to their configured start values and transfers continue.
- R7: In block mode (`cfg_mode` = 2), one trigger moves `cfg_size` units back to back with `bus_req` held high. The bus is then released for exactly one cycle before the next block.
- R8: A `cfg_size` of 0 means 65536 units.
- R9: With `cfg_trig` = 2 and `cfg_dreq_edge` = 1, a falling edge on `dreq_n` is latched. The latch is cleared when the transfer it starts begins, so a held-low pin yields one unit.
- R10: With `cfg_trig` = 2 and `cfg_dreq_edge` = 0, a low `dreq_n` is resampled before every unit. While the pin is high, no unit starts.
- R11: Auto-request (`cfg_trig` = 0) with `cfg_burst` = 1 runs units with no idle cycle between them. With `cfg_burst` = 0 it drops `bus_req` for exactly one cycle after each unit.
- R12: While `bus_req` is high and `bus_ack` is low, the address and direction are held. Clearing `cfg_en` lets the pending bus cycle finish, after which no further cycle starts.
- R13: With `cfg_trig` = 1, units start only while `irq_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Channel enable; low reloads the working state |
| cfg_mode | input | 2 | 0 normal, 1 repeat, 2 block |
| cfg_unit | input | 2 | 0 byte, 1 word, 2 longword |
| cfg_trig | input | 2 | 0 auto, 1 peripheral, 2 external pin |
| cfg_burst | input | 1 | Auto-request burst (1) or cycle steal (0) |
| cfg_free | input | 1 | Ignore total count |
| cfg_dreq_edge | input | 1 | External pin: 1 falling edge, 0 low level |
| cfg_src_addr | input | AW | Source start address |
| cfg_dst_addr | input | AW | Destination start address |
| cfg_total | input | CW | Total transfer size in bytes |
| cfg_size | input | RW | Repeat/block size in units, 0 = 2^RW |
| irq_req | input | 1 | Peripheral request level |
| dreq_n | input | 1 | External request, active low |
| bus_req | output | 1 | Bus cycle request |
| bus_we | output | 1 | 1 write, 0 read |
| bus_addr | output | AW | Cycle address |
| bus_unit | output | 2 | Cycle size, same code as cfg_unit |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Cycle completes at this edge |
| bus_rdata | input | 32 | Read data, valid with bus_ack |
| done | output | 1 | Total count exhausted |

## Verification
The hardest situation to reach is a disable that lands while a bus cycle is still unacknowledged. From the ports it looks just like a normal stop unless the acknowledge is withheld. The bench gates its zero-latency acknowledge, clears the enable during the stalled cycle, and confirms that the request stays high and the address does not move. It then releases the acknowledge and checks that the channel falls silent. The remaining modes are swept over every mode, unit size and arbitration style. Each written address and data word is compared against arithmetic expectations, and the idle gaps between units are measured.

// File: rtl/dma_chan_seq.sv
module dma_chan_seq #(
  parameter int AW = 32,
  parameter int CW = 32,
  parameter int RW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_en,
  input  logic [1:0]    cfg_mode,
  input  logic [1:0]    cfg_unit,
  input  logic [1:0]    cfg_trig,
  input  logic          cfg_burst,
  input  logic          cfg_free,
  input  logic          cfg_dreq_edge,
  input  logic [AW-1:0] cfg_src_addr,
  input  logic [AW-1:0] cfg_dst_addr,
  input  logic [CW-1:0] cfg_total,
  input  logic [RW-1:0] cfg_size,
  input  logic          irq_req,
  input  logic          dreq_n,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [1:0]    bus_unit,
  output logic [31:0]   bus_wdata,
  input  logic          bus_ack,
  input  logic [31:0]   bus_rdata,
  output logic          done
);
  localparam int RCW = RW + 1;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} st_t;
  st_t st;

  logic [AW-1:0]  src, dst;
  logic [CW-1:0]  rem;
  logic [RCW-1:0] rep;
  logic [31:0]    data;
  logic           dreq_q, dreq_lat, trig;

  wire [2:0]     ub3      = (cfg_unit == 2'd2) ? 3'd4 : (cfg_unit == 2'd1) ? 3'd2 : 3'd1;
  wire [CW-1:0]  ub_c     = CW'(ub3);
  wire [AW-1:0]  ub_a     = AW'(ub3);
  wire [RCW-1:0] rep_init = {(cfg_size == '0), cfg_size};
  wire           last_cnt = !cfg_free && (rem <= ub_c);
  wire           blk_end  = (rep == RCW'(1));
  wire           ext_edge = (cfg_trig == 2'd2) && cfg_dreq_edge;

  always_comb begin
    case (cfg_trig)
      2'd0:    trig = 1'b1;
      2'd1:    trig = irq_req;
      2'd2:    trig = cfg_dreq_edge ? dreq_lat : !dreq_n;
      default: trig = 1'b0;
    endcase
  end

  assign bus_req   = (st != S_IDLE);
  assign bus_we    = (st == S_WR);
  assign bus_addr  = (st == S_WR) ? dst : src;
  assign bus_unit  = cfg_unit;
  assign bus_wdata = data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      src      <= '0;
      dst      <= '0;
      rem      <= '0;
      rep      <= '0;
      data     <= '0;
      done     <= 1'b0;
      dreq_q   <= 1'b1;
      dreq_lat <= 1'b0;
    end else begin
      dreq_q <= dreq_n;
      if (dreq_q && !dreq_n) dreq_lat <= 1'b1;
      case (st)
        S_IDLE: begin
          if (!cfg_en) begin
            src      <= cfg_src_addr;
            dst      <= cfg_dst_addr;
            rem      <= cfg_total;
            rep      <= rep_init;
            done     <= 1'b0;
            dreq_lat <= 1'b0;
          end else if (!done) begin
            if (!cfg_free && rem == '0) done <= 1'b1;
            else if (trig) begin
              st <= S_RD;
              if (ext_edge) dreq_lat <= 1'b0;
            end
          end
        end
        S_RD: if (bus_ack) begin
          data <= bus_rdata;
          st   <= cfg_en ? S_WR : S_IDLE;
        end
        S_WR: if (bus_ack) begin
          src <= src + ub_a;
          dst <= dst + ub_a;
          rep <= rep - RCW'(1);
          if (!cfg_free) rem <= last_cnt ? '0 : rem - ub_c;
          if (last_cnt) begin
            done <= 1'b1;
            st   <= S_IDLE;
          end else if (!cfg_en) begin
            st <= S_IDLE;
          end else begin
            if (blk_end) begin
              rep <= rep_init;
              if (cfg_mode == 2'd1) begin
                src <= cfg_src_addr;
                dst <= cfg_dst_addr;
              end
            end
            if (cfg_mode == 2'd2) st <= blk_end ? S_IDLE : S_RD;
            else st <= (cfg_trig == 2'd0 && cfg_burst) ? S_RD : S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R12
  cycle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)));

  // R3
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !bus_req);

  // R4
  free_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && cfg_free && !done) |=> !done);

  // R11
  steal_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_ack && cfg_trig == 2'd0 && !cfg_burst && cfg_mode != 2'd2)
      |=> !bus_req);

  // R12
  disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en && !bus_req) |=> !bus_req);

  // R2
  read_then_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we && bus_ack && cfg_en) |=> (bus_req && bus_we));
endmodule

// File: tb/test_dma_chan_seq.sv
module test_dma_chan_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        cfg_en = 0, cfg_burst = 0, cfg_free = 0, cfg_dreq_edge = 0;
  logic [1:0]  cfg_mode = 0, cfg_unit = 0, cfg_trig = 0;
  logic [31:0] cfg_src_addr = 32'h1000, cfg_dst_addr = 32'h8000, cfg_total = 0;
  logic [15:0] cfg_size = 0;
  logic        irq_req = 0, dreq_n = 1, ack_gate = 1;
  logic        bus_req, bus_we, bus_ack, done;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic [1:0]  bus_unit;

  assign bus_ack   = bus_req & ack_gate;
  assign bus_rdata = bus_addr ^ 32'h5A5A_0000;

  dma_chan_seq i_dma_chan_seq (
    .clk, .rst_n, .cfg_en, .cfg_mode, .cfg_unit, .cfg_trig, .cfg_burst,
    .cfg_free, .cfg_dreq_edge, .cfg_src_addr, .cfg_dst_addr, .cfg_total,
    .cfg_size, .irq_req, .dreq_n, .bus_req, .bus_we, .bus_addr, .bus_unit,
    .bus_wdata, .bus_ack, .bus_rdata, .done);

  int nwr = 0, gapcnt = 0, cyc = 0, ntot = 0, nfail = 0;
  logic [31:0] waddr [256];
  logic [31:0] wdata [256];
  int          wgap  [256];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (bus_req && bus_we && bus_ack) begin
      waddr[nwr % 256] <= bus_addr;
      wdata[nwr % 256] <= bus_wdata;
      wgap[nwr % 256]  <= gapcnt;
      nwr    <= nwr + 1;
      gapcnt <= 0;
    end else if (!bus_req) gapcnt <= gapcnt + 1;
    if (cyc == 150000) begin
      nfail = nfail + 1; ntot = ntot + 1;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", ntot - nfail, ntot);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    ntot++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setup(input logic [1:0] m, input logic [1:0] u, input logic [1:0] t,
                       input logic b, input logic fr, input logic [31:0] tot, input logic [15:0] sz);
    @(negedge clk);
    cfg_en = 0; cfg_mode = m; cfg_unit = u; cfg_trig = t; cfg_burst = b;
    cfg_free = fr; cfg_total = tot; cfg_size = sz;
    cycles(2);
  endtask

  task automatic run_case(input int m, input int u, input int b, input logic [15:0] sz);
    int ub, reff, base, idx;
    ub   = (u == 2) ? 4 : (u == 1) ? 2 : 1;
    reff = (sz == 0) ? 65536 : int'(sz);
    setup(2'(m), 2'(u), 2'd0, 1'(b), 1'b0, 32'(6 * ub), sz);
    base = nwr;
    cfg_en = 1;
    for (int i = 0; i < 400 && !done; i++) cycles(1);
    // R3 done after total
    chk(done == 1'b1, "R3 done", done, 1);
    chk(nwr - base == 6, "R3 unit count", nwr - base, 6);
    for (int k = 0; k < 6; k++) begin
      int eg;
      idx = (m == 1) ? (k % reff) : k;
      // R2 R6 R8 addresses and data
      chk(waddr[(base + k) % 256] == 32'h8000 + 32'(idx * ub), "R2/R6/R8 dst addr",
          waddr[(base + k) % 256], 32'h8000 + idx * ub);
      chk(wdata[(base + k) % 256] == ((32'h1000 + 32'(idx * ub)) ^ 32'h5A5A_0000), "R2 data",
          wdata[(base + k) % 256], (32'h1000 + idx * ub) ^ 32'h5A5A_0000);
      if (k > 0) begin
        if (m == 2) eg = (k % reff == 0) ? 1 : 0;
        else eg = b ? 0 : 1;
        // R7 R11 R5 idle gap between units
        chk(wgap[(base + k) % 256] == eg, "R5/R7/R11 gap", wgap[(base + k) % 256], eg);
      end
    end
    chk(bus_req == 1'b0, "R3 quiet after done", bus_req, 0);
  endtask

  initial begin
    int n0, n1;
    cycles(3);
    // R1
    chk(bus_req == 1'b0 && done == 1'b0, "R1 reset", {bus_req, done}, 0);
    rst_n = 1;
    cycles(2);
    chk(bus_req == 1'b0 && done == 1'b0, "R1 after reset", {bus_req, done}, 0);

    for (int m = 0; m < 3; m++)
      for (int u = 0; u < 3; u++)
        for (int b = 0; b < 2; b++)
          run_case(m, u, b, 16'd4);
    // R8 size 0 = 65536 in repeat: no early reload
    run_case(1, 2, 1, 16'd0);
    run_case(2, 0, 1, 16'd0);

    // R3 zero total
    setup(2'd0, 2'd0, 2'd0, 1'b1, 1'b0, 32'd0, 16'd4);
    n0 = nwr; cfg_en = 1; cycles(10);
    chk(done == 1'b1, "R3 zero total done", done, 1);
    chk(nwr == n0, "R3 zero total no write", nwr - n0, 0);

    // R9 edge request
    setup(2'd0, 2'd0, 2'd2, 1'b0, 1'b0, 32'd400, 16'd4);
    cfg_dreq_edge = 1; n0 = nwr; cfg_en = 1; cycles(10);
    chk(nwr == n0, "R9 no edge", nwr - n0, 0);
    dreq_n = 0; cycles(20);
    chk(nwr - n0 == 1, "R9 one unit per edge", nwr - n0, 1);
    dreq_n = 1; cycles(3); dreq_n = 0; cycles(20);
    chk(nwr - n0 == 2, "R9 second edge", nwr - n0, 2);
    dreq_n = 1;

    // R10 level request
    setup(2'd0, 2'd0, 2'd2, 1'b0, 1'b0, 32'd400, 16'd4);
    cfg_dreq_edge = 0; n0 = nwr; cfg_en = 1; cycles(10);
    chk(nwr == n0, "R10 high pin idle", nwr - n0, 0);
    dreq_n = 0; cycles(20);
    chk(nwr - n0 >= 5, "R10 level repeats", nwr - n0, 5);
    dreq_n = 1; cycles(5); n1 = nwr; cycles(20);
    chk(nwr == n1, "R10 stops when high", nwr - n1, 0);

    // R13 peripheral request
    setup(2'd0, 2'd1, 2'd1, 1'b0, 1'b0, 32'd400, 16'd4);
    n0 = nwr; cfg_en = 1; cycles(10);
    chk(nwr == n0, "R13 no irq", nwr - n0, 0);
    irq_req = 1; cycles(12);
    chk(nwr - n0 >= 3, "R13 irq moves", nwr - n0, 3);
    irq_req = 0; cycles(5); n1 = nwr; cycles(15);
    chk(nwr == n1, "R13 irq low halts", nwr - n1, 0);

    // R4 free running, then R12 disable during stalled cycle
    setup(2'd0, 2'd2, 2'd0, 1'b1, 1'b1, 32'd8, 16'd4);
    n0 = nwr; cfg_en = 1; cycles(100);
    chk(done == 1'b0, "R4 free never done", done, 0);
    chk(nwr - n0 >= 40, "R4 free keeps moving", nwr - n0, 40);
    ack_gate = 0; cycles(2);
    n1 = nwr; cfg_en = 0; cycles(3);
    chk(bus_req == 1'b1, "R12 pending cycle held", bus_req, 1);
    ack_gate = 1; cycles(2);
    chk(bus_req == 1'b0, "R12 stopped after cycle", bus_req, 0);
    n1 = nwr; cycles(20);
    chk(nwr == n1 && bus_req == 1'b0, "R12 stays stopped", nwr - n1, 0);

    $display("%0d/%0d checks passed", ntot - nfail, ntot);
    $finish;
  end
endmodule